// File: doc/BRIEF.md
# Command Buffer Packer with Burst Coalescing

This block turns a stream of register-write requests into the instruction stream that a downstream register-programming executor reads. Each request carries a 20-bit register offset, a 32-bit value and a kind flag (direct or indexed). The packer stores the resulting dwords in a local buffer, one dword per cycle. It keeps the fill level, which is the next free dword index, and the start index of the instruction it is currently building.

A direct request becomes a two-dword instruction: the value first, then a command dword. An indexed request opens a new burst instruction on an even dword boundary. A later indexed request to the same offset appends its value to that burst and raises the burst's count word in place, so a run of writes to an auto-incrementing register costs one dword each. When the fill level ends odd, a zero dword is written there as padding. A request that arrives with the buffer full is discarded and sets a sticky overflow flag. A clear pulse, issued after the buffer is committed, rewinds the fill level and forgets the open instruction. The executor reads the buffer through a combinational read port.

Top module: `cmd_packer`

## Requirements
- R1: A direct request accepted at fill level p stores the value at index p and the command dword at p+1. The command dword holds opcode 0x01 in bits 31:24, byte enable 0xF in bits 23:20 and the offset in bits 19:0. The fill level becomes p+2.
- R2: An indexed request that does not extend the open burst rounds p up to the even index a. It writes count 1 at a, a command dword with opcode 0x09 in bits 31:24, zero in bits 23:20 and the offset in bits 19:0 at a+1, the value at a+2 and zero at a+3. The fill level becomes a+3.
- R3: An indexed request whose offset equals the offset of the open burst instruction stores its value at p, increments the count word at the burst's start index, and sets the fill level to p+1.
- R4: An instruction built from a direct request is never extended. An indexed request to that same offset opens a new burst.
- R5: Whenever a request leaves the fill level odd, the dword at the fill level is zero.
- R6: The buffer takes one dword per cycle. After an accepted request, req_ready stays low for exactly as many cycles as that request writes dwords:
  - direct: 2, or 3 with a pad;
  - new burst: 4;
  - append: 2, or 3 with a pad.
- R7: A request that arrives while the fill level is at or above DEPTH writes nothing, leaves the fill level unchanged, keeps req_ready high and sets overflow.
- R8: Overflow stays set until rst_n is asserted. Clear does not reset it.
- R9: Clear sets the fill level and the start index to zero and closes the open burst. The next indexed request starts a new burst at index 0, even if its offset matches the old burst.
- R10: After reset, fill is 0, overflow is 0 and req_ready is 1.
- R11: Dwords that fall at index DEPTH or above are discarded without wrapping into the buffer. rd_data returns the dword stored at rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Rewind after commit: fill and open instruction cleared |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Packer idle, request accepted this cycle |
| req_indexed | input | 1 | 1 = indexed (burst) write, 0 = direct write |
| req_ofs | input | 20 | Register offset |
| req_val | input | 32 | Value to write |
| fill | output | $clog2(DEPTH)+2 | Fill level in dwords (next free index) |
| overflow | output | 1 | Sticky: a request was dropped on a full buffer |
| rd_addr | input | $clog2(DEPTH) | Buffer read index |
| rd_data | output | 32 | Buffer dword at rd_addr |

## Verification
The stimulus mixes several patterns:
- a lone direct write;
- a fresh burst followed by same-offset appends, which separates merging from opening;
- direct and indexed writes at odd fill levels, which exercise alignment and both pad placements;
- an indexed write to the offset of a preceding direct write, and one after a clear, which must both open new bursts and so show whether the burst test looks at the opcode and at the clear.

A fill run that ends with a burst straddling DEPTH, followed by a dropped request, tells discarding apart from wrapping, and a later clear tells the sticky flag apart from the fill rewind.

// File: rtl/cmd_packer.sv
module cmd_packer #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_indexed,
  input  logic [19:0]   req_ofs,
  input  logic [31:0]   req_val,
  output logic [PW-1:0] fill,
  output logic          overflow,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  typedef enum logic [1:0] {OP_DIR, OP_NEW, OP_APP} op_t;

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] free_q, start_q, base_q;
  logic [31:0]   val_q, cnt_q;
  logic [19:0]   ofs_q, cur_ofs;
  logic          cur_idx, busy_q, ovf_q;
  logic [1:0]    step_q, last_q;
  op_t           op_q;

  logic          accept, room, merge, wr_en;
  logic [PW-1:0] aligned, wr_addr;
  logic [31:0]   wr_data;

  assign accept  = req_valid && !busy_q && !clear;
  assign room    = free_q < PW'(DEPTH);
  assign merge   = req_indexed && cur_idx && (req_ofs == cur_ofs);
  assign aligned = free_q + PW'(free_q[0]);

  assign req_ready = !busy_q;
  assign fill      = free_q;
  assign overflow  = ovf_q;
  assign rd_data   = mem[rd_addr];

  always_comb begin
    wr_addr = base_q;
    wr_data = 32'h0;
    unique case (op_q)
      OP_DIR: case (step_q)
        2'd0:    wr_data = val_q;
        2'd1:    begin wr_addr = base_q + 1'b1; wr_data = {8'h01, 4'hF, ofs_q}; end
        default: wr_addr = base_q + 2'd2;
      endcase
      OP_NEW: case (step_q)
        2'd0:    wr_data = 32'd1;
        2'd1:    begin wr_addr = base_q + 1'b1; wr_data = {8'h09, 4'h0, ofs_q}; end
        2'd2:    begin wr_addr = base_q + 2'd2; wr_data = val_q; end
        default: wr_addr = base_q + 2'd3;
      endcase
      default: case (step_q)
        2'd0:    wr_data = val_q;
        2'd1:    begin wr_addr = start_q; wr_data = cnt_q; end
        default: wr_addr = base_q + 1'b1;
      endcase
    endcase
  end

  assign wr_en = busy_q && (wr_addr < PW'(DEPTH));

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr[AW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '0; start_q <= '0; base_q <= '0;
      val_q <= '0; cnt_q <= '0; ofs_q <= '0; cur_ofs <= '0;
      cur_idx <= 1'b0; busy_q <= 1'b0; ovf_q <= 1'b0;
      step_q <= '0; last_q <= '0; op_q <= OP_DIR;
    end else if (clear) begin
      free_q <= '0; start_q <= '0; cur_idx <= 1'b0; busy_q <= 1'b0;
    end else if (busy_q) begin
      step_q <= step_q + 1'b1;
      if (step_q == last_q) busy_q <= 1'b0;
    end else if (accept && !room) begin
      ovf_q <= 1'b1;
    end else if (accept) begin
      busy_q <= 1'b1;
      step_q <= '0;
      val_q  <= req_val;
      ofs_q  <= req_ofs;
      if (!req_indexed) begin
        op_q    <= OP_DIR;
        base_q  <= free_q;
        start_q <= free_q;
        free_q  <= free_q + 2'd2;
        cur_idx <= 1'b0;
        last_q  <= free_q[0] ? 2'd2 : 2'd1;
      end else if (merge) begin
        op_q   <= OP_APP;
        base_q <= free_q;
        free_q <= free_q + 1'b1;
        cnt_q  <= cnt_q + 1'b1;
        last_q <= free_q[0] ? 2'd1 : 2'd2;
      end else begin
        op_q    <= OP_NEW;
        base_q  <= aligned;
        start_q <= aligned;
        free_q  <= aligned + 2'd3;
        cnt_q   <= 32'd1;
        cur_idx <= 1'b1;
        cur_ofs <= req_ofs;
        last_q  <= 2'd3;
      end
    end
  end
endmodule

// File: rtl/cmd_packer_chk.sv
module cmd_packer_chk #(
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH) + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          req_valid,
  input logic          req_ready,
  input logic [PW-1:0] fill,
  input logic          overflow
);
  assert_sticky_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_clear_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> fill == '0);

  assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !clear && fill >= PW'(DEPTH)) |=> (overflow && $stable(fill) && req_ready));

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !clear && fill < PW'(DEPTH)) |=> !req_ready);

  assert_fill_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> fill >= $past(fill));
endmodule

bind cmd_packer cmd_packer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .req_valid(req_valid),
  .req_ready(req_ready), .fill(fill), .overflow(overflow)
);

// File: tb/cmd_packer_bench.sv
`timescale 1ns/1ps
module cmd_packer_bench;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 2;

  logic clk = 0, rst_n = 0, clear = 0, req_valid = 0, req_indexed = 0;
  logic req_ready, overflow;
  logic [19:0] req_ofs = '0;
  logic [31:0] req_val = '0, rd_data;
  logic [PW-1:0] fill;
  logic [AW-1:0] rd_addr = '0;

  always #2.5 clk = ~clk;

  cmd_packer #(.DEPTH(DEPTH)) u_cmd_packer (
    .clk(clk), .rst_n(rst_n), .clear(clear), .req_valid(req_valid),
    .req_ready(req_ready), .req_indexed(req_indexed), .req_ofs(req_ofs),
    .req_val(req_val), .fill(fill), .overflow(overflow),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  int m_free = 0, m_start = 0;
  bit m_open = 0, m_ovf = 0;
  logic [31:0] m_mem [DEPTH + 8];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R1", "fill tracks model", 32'(fill), 32'(m_free));
      chk("R8", "overflow tracks model", 32'(overflow), 32'(m_ovf));
    end
  end

  task automatic sweep(string tag);
    int top = m_free + (m_free % 2);
    if (top > DEPTH) top = DEPTH;
    for (int i = 0; i < top; i++) begin
      rd_addr = AW'(i);
      #0.1;
      chk(tag, $sformatf("buffer[%0d]", i), rd_data, m_mem[i]);
    end
  endtask

  task automatic send(bit idx, logic [19:0] ofs, logic [31:0] val, string tag);
    int n = 0, p, a, waited = 0;
    @(negedge clk);
    req_valid = 1; req_indexed = idx; req_ofs = ofs; req_val = val;
    @(posedge clk);
    p = m_free;
    if (m_free >= DEPTH) m_ovf = 1;
    else if (!idx) begin
      m_mem[p] = val; m_mem[p+1] = {8'h01, 4'hF, ofs};
      m_start = p; m_free = p + 2; m_open = 1; n = 2;
      if (m_free % 2) begin m_mem[m_free] = 0; n = 3; end
    end else if (m_open && m_mem[m_start+1][31:24] == 8'h09 && m_mem[m_start+1][19:0] == ofs) begin
      m_mem[p] = val; m_mem[m_start] = m_mem[m_start] + 1;
      m_free = p + 1; n = 2;
      if (m_free % 2) begin m_mem[m_free] = 0; n = 3; end
    end else begin
      a = p + (p % 2);
      m_mem[a] = 1; m_mem[a+1] = {8'h09, 4'h0, ofs}; m_mem[a+2] = val; m_mem[a+3] = 0;
      m_start = a; m_free = a + 3; m_open = 1; n = 4;
    end
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) begin waited++; @(negedge clk); end
    chk(tag, "busy cycles R6", 32'(waited), 32'(n));
    sweep(tag);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(posedge clk); m_free = 0; m_start = 0; m_open = 0;
    @(negedge clk); clear = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    m_free = 0; m_start = 0; m_open = 0; m_ovf = 0;
    repeat (2) @(negedge clk);
    chk("R10", "fill in reset", 32'(fill), 0);
    chk("R10", "overflow in reset", 32'(overflow), 0);
    chk("R10", "ready in reset", 32'(req_ready), 1);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    send(0, 20'h00100, 32'hA0A0_0001, "R1");
    send(1, 20'h00200, 32'hB0B0_0002, "R2");
    send(1, 20'h00200, 32'hC0C0_0003, "R3");
    send(1, 20'h00200, 32'hD0D0_0004, "R3 R5");
    send(0, 20'h00300, 32'hE0E0_0005, "R5");
    send(1, 20'h00300, 32'hF0F0_0006, "R4");
    send(1, 20'h00400, 32'h1111_0007, "R2");
    send(1, 20'h00400, 32'h2222_0008, "R3");
    do_clear();
    send(1, 20'h00400, 32'h3333_0009, "R9");
    send(1, 20'h00400, 32'h4444_000A, "R9 R3");
    do_clear();
    for (int k = 0; k < DEPTH / 2 - 1; k++)
      send(0, 20'(k), 32'h5000_0000 + 32'(k), "R1 fill");
    send(1, 20'h00500, 32'h6666_000B, "R11");
    send(0, 20'h00600, 32'h7777_000C, "R7");
    chk("R7", "overflow after drop", 32'(overflow), 1);
    do_clear();
    chk("R8", "overflow survives clear", 32'(overflow), 1);
    send(0, 20'h00700, 32'h8888_000D, "R8 R1");
    do_reset();
    send(1, 20'h00800, 32'h9999_000E, "R10 R2");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule